// File: doc/BRIEF.md
# Power-Down and Resynchronisation Controller

This block sequences reset and power-down for an audio sub-band filter and codec device. It runs on a free-running reference clock. After the external reset is released it keeps the internal reset asserted for a fixed number of reference cycles. After a power-down request is removed it does the same again, for a longer span that also covers oscillator start-up. While power-down is requested, the clock enable for all internally generated clocks is removed. The controller's own state is frozen, and every bidirectional pin group loses its output enable.

The block also watches the inputs whose changes break clock or data continuity. These are the master-clock frequency select, the bit-rate select, the filtered-data direction, and the direction of the baseband clock outputs (which decides whether those clock pins are driven or left floating). Any change to one of them starts two resynchronisation pulses. One goes to the companion masking processor and one to the digital audio interface. Each pulse has its own fixed length, and a further change restarts both pulses. Both pulses are also held high for as long as the internal reset is active.

Top module: `pwrseq_resync`

## Requirements
- R1: After `sysRst` is released, `intRst` stays high for exactly REF_CYC+1 (default 25) rising clock edges and is low after the next one.
- R2: At the first rising edge that samples `pwrDown` low after it was sampled high, `intRst` rises and stays high for REF_CYC+OSC_START_CYC (default 64) edges in total.
- R3: `clkEn` is low exactly while `pwrDown` is high.
- R4: While `pwrDown` is sampled high, clock edges change neither `intRst` nor either resync output, and the remaining pulse and reset lengths resume where they stopped.
- R5: `oeBaseClk`, `oeFlt` and `oeSub` equal `baseDir`, `fltDir` and `subDir` respectively (1 = drive) while `pwrDown` is low, and are all 0 while it is high.
- R6: A change of `baseDir` (baseband clock outputs switching between driven and floating) sampled at an active edge raises both resync outputs after that edge.
- R7: A change of `freqSel` (codes 0, 1, 2 select the three master-clock frequencies) sampled at an active edge raises both resync outputs after that edge.
- R8: A change of `fltDir` or of `rateSel` sampled at an active edge raises both resync outputs after that edge.
- R9: Absent reset, `resyncPeer` stays high for PEER_PULSE_CYC (default 8) edges and `resyncAudio` for AUDIO_PULSE_CYC (default 4) edges, counted from the edge that sees the change. Another change while a pulse runs restarts its full length.
- R10: Both resync outputs are high whenever `intRst` is high.
- R11: A change of `subDir` raises neither resync output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| sysRst | input | 1 | External system reset, active high, asynchronous |
| pwrDown | input | 1 | Power-down request, active high |
| baseDir | input | 1 | 1 = block drives master clock, bit clock and word select |
| fltDir | input | 1 | 1 = block drives filtered-data pins |
| subDir | input | 1 | 1 = block drives sub-band coded bus |
| freqSel | input | FREQ_W | Master-clock frequency select |
| rateSel | input | RATE_W | Coded bit-rate select |
| intRst | output | 1 | Stretched internal reset |
| clkEn | output | 1 | Enable for all internally generated clocks |
| oeBaseClk | output | 1 | Output enable, baseband clock pins |
| oeFlt | output | 1 | Output enable, filtered-data pins |
| oeSub | output | 1 | Output enable, sub-band bus pins |
| resyncPeer | output | 1 | Resync pulse to the companion processor |
| resyncAudio | output | 1 | Resync pulse to the digital audio interface |

## Verification
The hardest case to reach is a continuity event that lands inside a power-down window or inside a running pulse. Here the frozen counters and the held change references must combine correctly with the reset stretch that follows release. The stimulus gets there in two ways. Directed sequences change `freqSel` while `pwrDown` is high and retrigger a pulse a few cycles into it. A seeded random phase then sets power-down episodes against sparse input changes, and each cycle is compared with a bench model.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  // strobes from the sequencing control to the event datapath
  typedef struct packed {
    logic hold;   // power-down: freeze all state
    logic rstOn;  // stretched reset active
  } ctlStrb_t;
endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int REF_CYC       = 24,
  parameter int OSC_START_CYC = 40
) (
  input  logic     clk,
  input  logic     sysRst,
  input  logic     pwrDown,
  input  logic     baseDir,
  input  logic     fltDir,
  input  logic     subDir,
  output logic     intRst,
  output logic     clkEn,
  output logic     oeBaseClk,
  output logic     oeFlt,
  output logic     oeSub,
  output ctlStrb_t strb
);
  localparam int POR_LOAD = REF_CYC + 1;
  localparam int PD_LOAD  = REF_CYC + OSC_START_CYC;
  localparam int MAX_LOAD = (POR_LOAD > PD_LOAD) ? POR_LOAD : PD_LOAD;
  localparam int CNT_W    = $clog2(MAX_LOAD + 1);
  localparam int N_OE     = 3;

  logic             pdQ;
  logic [CNT_W-1:0] rstCnt;
  logic [N_OE-1:0]  dirVec;
  logic [N_OE-1:0]  oeVec;

  // reset stretch: loaded on power-on and on power-down release, frozen while down
  always_ff @(posedge clk or posedge sysRst) begin
    if (sysRst) begin
      pdQ    <= 1'b0;
      rstCnt <= CNT_W'(POR_LOAD);
    end else begin
      pdQ <= pwrDown;
      if (pdQ && !pwrDown)
        rstCnt <= CNT_W'(PD_LOAD);
      else if (!pwrDown && rstCnt != '0)
        rstCnt <= rstCnt - 1'b1;
    end
  end

  assign intRst = (rstCnt != '0);
  assign clkEn  = ~pwrDown;

  assign dirVec = {subDir, fltDir, baseDir};
  for (genvar gi = 0; gi < N_OE; gi++) begin : g_oe
    assign oeVec[gi] = dirVec[gi] & ~pwrDown;
  end
  assign oeBaseClk = oeVec[0];
  assign oeFlt     = oeVec[1];
  assign oeSub     = oeVec[2];

  assign strb.hold  = pwrDown;
  assign strb.rstOn = intRst;
endmodule

// File: rtl/pwrseq_dpath.sv
module pwrseq_dpath
  import pwrseq_pkg::*;
#(
  parameter int FREQ_W          = 2,
  parameter int RATE_W          = 4,
  parameter int PEER_PULSE_CYC  = 8,
  parameter int AUDIO_PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              sysRst,
  input  ctlStrb_t          strb,
  input  logic [FREQ_W-1:0] freqSel,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              baseDir,
  input  logic              fltDir,
  output logic              resyncPeer,
  output logic              resyncAudio
);
  localparam int WATCH_W = FREQ_W + RATE_W + 2;
  localparam int MAX_LEN = (PEER_PULSE_CYC > AUDIO_PULSE_CYC) ? PEER_PULSE_CYC : AUDIO_PULSE_CYC;
  localparam int PLS_W   = $clog2(MAX_LEN + 1);
  localparam int N_CH    = 2;

  logic [WATCH_W-1:0] watchNow, watchQ;
  logic               chgStrb;
  logic [N_CH-1:0]    pulseOut;

  assign watchNow = {freqSel, rateSel, fltDir, baseDir};

  // reference copies only move while the device is awake
  always_ff @(posedge clk or posedge sysRst) begin
    if (sysRst)          watchQ <= '0;
    else if (!strb.hold) watchQ <= watchNow;
  end

  assign chgStrb = (watchNow != watchQ) && !strb.hold;

  for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
    localparam int LEN = (gi == 0) ? PEER_PULSE_CYC : AUDIO_PULSE_CYC;
    logic [PLS_W-1:0] pCnt;
    always_ff @(posedge clk or posedge sysRst) begin
      if (sysRst)
        pCnt <= '0;
      else if (!strb.hold) begin
        if (chgStrb)          pCnt <= PLS_W'(LEN);
        else if (pCnt != '0)  pCnt <= pCnt - 1'b1;
      end
    end
    assign pulseOut[gi] = (pCnt != '0) || strb.rstOn;
  end

  assign resyncPeer  = pulseOut[0];
  assign resyncAudio = pulseOut[1];
endmodule

// File: rtl/pwrseq_resync.sv
module pwrseq_resync
  import pwrseq_pkg::*;
#(
  parameter int REF_CYC         = 24,
  parameter int OSC_START_CYC   = 40,
  parameter int FREQ_W          = 2,
  parameter int RATE_W          = 4,
  parameter int PEER_PULSE_CYC  = 8,
  parameter int AUDIO_PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              sysRst,
  input  logic              pwrDown,
  input  logic              baseDir,
  input  logic              fltDir,
  input  logic              subDir,
  input  logic [FREQ_W-1:0] freqSel,
  input  logic [RATE_W-1:0] rateSel,
  output logic              intRst,
  output logic              clkEn,
  output logic              oeBaseClk,
  output logic              oeFlt,
  output logic              oeSub,
  output logic              resyncPeer,
  output logic              resyncAudio
);
  ctlStrb_t strb;

  pwrseq_ctrl #(
    .REF_CYC(REF_CYC), .OSC_START_CYC(OSC_START_CYC)
  ) u_ctrl (
    .clk(clk), .sysRst(sysRst), .pwrDown(pwrDown),
    .baseDir(baseDir), .fltDir(fltDir), .subDir(subDir),
    .intRst(intRst), .clkEn(clkEn),
    .oeBaseClk(oeBaseClk), .oeFlt(oeFlt), .oeSub(oeSub),
    .strb(strb)
  );

  pwrseq_dpath #(
    .FREQ_W(FREQ_W), .RATE_W(RATE_W),
    .PEER_PULSE_CYC(PEER_PULSE_CYC), .AUDIO_PULSE_CYC(AUDIO_PULSE_CYC)
  ) u_dpath (
    .clk(clk), .sysRst(sysRst), .strb(strb),
    .freqSel(freqSel), .rateSel(rateSel),
    .baseDir(baseDir), .fltDir(fltDir),
    .resyncPeer(resyncPeer), .resyncAudio(resyncAudio)
  );
endmodule

// File: rtl/pwrseq_resync_chk.sv
module pwrseq_resync_chk #(
  parameter int FREQ_W = 2,
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              sysRst,
  input logic              pwrDown,
  input logic              baseDir,
  input logic              fltDir,
  input logic [FREQ_W-1:0] freqSel,
  input logic [RATE_W-1:0] rateSel,
  input logic              intRst,
  input logic              resyncPeer,
  input logic              resyncAudio
);
  AST_PD_RELEASE_RST: assert property (@(posedge clk) disable iff (sysRst)
    ($past(pwrDown) && !pwrDown) |=> intRst); // R2

  AST_PD_FREEZE: assert property (@(posedge clk) disable iff (sysRst)
    $past(pwrDown) |-> ($stable(intRst) && $stable(resyncPeer) && $stable(resyncAudio))); // R4

  AST_BASEDIR_RESYNC: assert property (@(posedge clk) disable iff (sysRst)
    (!pwrDown && !$past(pwrDown) && baseDir != $past(baseDir)) |=> (resyncPeer && resyncAudio)); // R6

  AST_FREQ_RESYNC: assert property (@(posedge clk) disable iff (sysRst)
    (!pwrDown && !$past(pwrDown) && freqSel != $past(freqSel)) |=> (resyncPeer && resyncAudio)); // R7

  AST_FLTDIR_RESYNC: assert property (@(posedge clk) disable iff (sysRst)
    (!pwrDown && !$past(pwrDown) && fltDir != $past(fltDir)) |=> (resyncPeer && resyncAudio)); // R8

  AST_RATE_RESYNC: assert property (@(posedge clk) disable iff (sysRst)
    (!pwrDown && !$past(pwrDown) && rateSel != $past(rateSel)) |=> (resyncPeer && resyncAudio)); // R8
endmodule

bind pwrseq_resync pwrseq_resync_chk #(.FREQ_W(FREQ_W), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .sysRst(sysRst), .pwrDown(pwrDown), .baseDir(baseDir), .fltDir(fltDir),
  .freqSel(freqSel), .rateSel(rateSel), .intRst(intRst),
  .resyncPeer(resyncPeer), .resyncAudio(resyncAudio)
);

// File: tb/pwrseq_resync_tb.sv
module pwrseq_resync_tb;
  localparam int REF_CYC = 24, OSC_START_CYC = 40, FREQ_W = 2, RATE_W = 4;
  localparam int PA = 8, PB = 4;
  localparam int POR_LEN = REF_CYC + 1, PD_LEN = REF_CYC + OSC_START_CYC;

  logic clk = 1'b0, sysRst = 1'b1, pwrDown = 1'b0;
  logic baseDir = 1'b0, fltDir = 1'b0, subDir = 1'b0;
  logic [FREQ_W-1:0] freqSel = '0;
  logic [RATE_W-1:0] rateSel = '0;
  logic intRst, clkEn, oeBaseClk, oeFlt, oeSub, resyncPeer, resyncAudio;

  int nTests = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwrseq_resync #(.REF_CYC(REF_CYC), .OSC_START_CYC(OSC_START_CYC), .FREQ_W(FREQ_W),
    .RATE_W(RATE_W), .PEER_PULSE_CYC(PA), .AUDIO_PULSE_CYC(PB)) u_dut (
    .clk(clk), .sysRst(sysRst), .pwrDown(pwrDown), .baseDir(baseDir), .fltDir(fltDir),
    .subDir(subDir), .freqSel(freqSel), .rateSel(rateSel), .intRst(intRst), .clkEn(clkEn),
    .oeBaseClk(oeBaseClk), .oeFlt(oeFlt), .oeSub(oeSub),
    .resyncPeer(resyncPeer), .resyncAudio(resyncAudio));

  // reference model built from the requirements
  int mRst, mA, mB;
  bit mPdPrev, mBase, mFlt;
  logic [FREQ_W-1:0] mFreq;
  logic [RATE_W-1:0] mRate;

  always @(posedge clk or posedge sysRst) begin
    if (sysRst) begin
      mRst = POR_LEN; mA = 0; mB = 0; mPdPrev = 0;
      mBase = 0; mFlt = 0; mFreq = '0; mRate = '0;
    end else begin
      if (mPdPrev && !pwrDown) mRst = PD_LEN;
      else if (!pwrDown && mRst > 0) mRst = mRst - 1;
      mPdPrev = pwrDown;
      if (!pwrDown) begin
        if (baseDir != mBase || fltDir != mFlt || freqSel != mFreq || rateSel != mRate) begin
          mA = PA; mB = PB;
        end else begin
          if (mA > 0) mA = mA - 1;
          if (mB > 0) mB = mB - 1;
        end
        mBase = baseDir; mFlt = fltDir; mFreq = freqSel; mRate = rateSel;
      end
    end
  end

  function automatic bit expRst(); return mRst != 0; endfunction
  function automatic bit expPeer(); return (mA != 0) || (mRst != 0); endfunction
  function automatic bit expAudio(); return (mB != 0) || (mRst != 0); endfunction

  task automatic chk(string tag, logic act, logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk("R1 R2 intRst", intRst, expRst());
    chk("R3 clkEn", clkEn, !pwrDown);
    chk("R5 oeBaseClk", oeBaseClk, baseDir && !pwrDown);
    chk("R5 oeFlt", oeFlt, fltDir && !pwrDown);
    chk("R5 oeSub", oeSub, subDir && !pwrDown);
    chk("R6 R7 R8 R9 R10 resyncPeer", resyncPeer, expPeer());
    chk("R6 R7 R8 R9 R10 resyncAudio", resyncAudio, expAudio());
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      checkAll();
    end
  endtask

  bit holdA, holdB, holdR;

  initial begin
    void'($urandom(32'h5eed_0a17));
    repeat (3) @(posedge clk);
    #2;
    // reset state
    chk("R1 reset intRst", intRst, 1'b1);
    chk("R10 reset resyncPeer", resyncPeer, 1'b1);
    chk("R10 reset resyncAudio", resyncAudio, 1'b1);
    chk("R5 reset oeSub", oeSub, 1'b0);
    sysRst = 1'b0;
    // R1: high through edge 24, low after edge 25
    tick(POR_LEN - 1);
    chk("R1 intRst before end", intRst, 1'b1);
    tick(1);
    chk("R1 intRst released", intRst, 1'b0);
    tick(PA + 2);

    // R7 and R9: frequency change, pulse lengths
    freqSel = 2'd1;
    tick(1);
    chk("R7 peer raised", resyncPeer, 1'b1);
    chk("R7 audio raised", resyncAudio, 1'b1);
    tick(PB - 1);
    chk("R9 audio last", resyncAudio, 1'b1);
    tick(1);
    chk("R9 audio end", resyncAudio, 1'b0);
    tick(PA - PB - 1);
    chk("R9 peer last", resyncPeer, 1'b1);
    tick(1);
    chk("R9 peer end", resyncPeer, 1'b0);
    tick(2);

    // R8 and R9 retrigger
    rateSel = 4'd5;
    tick(3);
    fltDir = 1'b1;
    tick(PA);
    chk("R9 retrigger peer held", resyncPeer, 1'b1);
    chk("R8 oeFlt follows", oeFlt, 1'b1);
    tick(1);
    chk("R9 retrigger peer end", resyncPeer, 1'b0);
    tick(2);

    // R11: subDir ignored
    subDir = 1'b1;
    tick(2);
    chk("R11 peer quiet", resyncPeer, 1'b0);
    chk("R11 audio quiet", resyncAudio, 1'b0);
    chk("R5 oeSub driven", oeSub, 1'b1);

    // R6: clock outputs change drive state
    baseDir = 1'b1;
    tick(1);
    chk("R6 peer raised", resyncPeer, 1'b1);
    chk("R6 audio raised", resyncAudio, 1'b1);
    tick(2);

    // R3 R4 R5: power-down mid-pulse, input change while down
    pwrDown = 1'b1;
    holdA = resyncPeer; holdB = resyncAudio; holdR = intRst;
    tick(1);
    chk("R3 clkEn off", clkEn, 1'b0);
    chk("R5 oeBaseClk off", oeBaseClk, 1'b0);
    freqSel = 2'd2;
    tick(6);
    chk("R4 peer frozen", resyncPeer, holdA);
    chk("R4 audio frozen", resyncAudio, holdB);
    chk("R4 intRst frozen", intRst, holdR);
    pwrDown = 1'b0;
    tick(1);
    chk("R2 intRst on release", intRst, 1'b1);
    tick(PD_LEN - 1);
    chk("R2 intRst last", intRst, 1'b1);
    tick(1);
    chk("R2 intRst end", intRst, 1'b0);
    tick(PA + 2);

    // seeded random phase
    for (int c = 0; c < 2500; c++) begin
      if (pwrDown) begin
        if ($urandom_range(99) < 8) pwrDown = 1'b0;
      end else if ($urandom_range(999) < 15) pwrDown = 1'b1;
      if ($urandom_range(99) < 3) freqSel = FREQ_W'($urandom_range(2));
      if ($urandom_range(99) < 2) rateSel = RATE_W'($urandom);
      if ($urandom_range(99) < 2) fltDir = ~fltDir;
      if ($urandom_range(99) < 2) baseDir = ~baseDir;
      if ($urandom_range(99) < 4) subDir = ~subDir;
      tick(1);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule